// File: doc/BRIEF.md
# Prescaled Transfer Hang Watchdog

This block watches two data channels, one for the receive direction and one for the transmit direction, and reports when either has waited too long for data. Each channel has its own prescaler, which divides the system clock down to a slow tick. The tick threshold is a base count of 8000 shifted right by a 3-bit shift value. A saturating timeout counter counts these ticks while the channel signals that it is waiting. When the count reaches a programmed 8-bit limit and one more tick arrives, the channel's sticky hang bit is raised.

Any activity strobe on a channel clears both of its counters. An idle channel therefore never reports a hang. The two hang bits form a small interrupt group with raw, enable, masked status and clear controls. The group drives a single interrupt line.

Bit 0 of every two-bit vector belongs to the receive channel and bit 1 to the transmit channel.

Top module: `hang_watchdog`

## Requirements
- R1: Each prescaler counts clock cycles from zero up to T = 8000 >> shift. In the cycle where the count is at or above T, one tick is issued and the count returns to zero. A tick therefore comes every T+1 cycles, so shift 0 gives 8001 cycles and shift 7 gives 63 cycles.
- R2: While enabled and waiting, with limit L, the raw hang bit rises at the clock edge that ends the (L+1)-th tick after the last activity strobe. That edge comes (L+1)*(T+1) edges after the edge that sampled the strobe, and not before.
- R3: A limit of zero raises the hang on the first tick, T+1 edges after the strobe.
- R4: While a channel's enable is low, its prescaler and timeout counter are held at zero and no new hang is raised.
- R5: While a channel's waiting input is low, its timeout counter is held at zero and no hang is raised. Once waiting returns with limit zero, a hang follows within one tick period.
- R6: An activity strobe clears the channel's prescaler and timeout counter, so the hang timing restarts from the strobe.
- R7: A raw hang bit stays set until a one is applied on its clear bit. If a hang is raised in the same cycle as a clear, the raised hang wins and the bit stays set.
- R8: irq_status equals irq_raw ANDed with irq_ena, and irq_o is high exactly when any irq_status bit is high.
- R9: The two channels are independent: a hang on one never changes the other's raw bit.
- R10: The timeout counter saturates at 255 and does not wrap. With limit 255 and waiting held, a cleared hang is raised again on the very next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive watchdog enable |
| rx_limit | input | 8 | Receive timeout limit in ticks |
| rx_shift | input | 3 | Receive prescaler shift |
| rx_waiting | input | 1 | Receive channel is waiting for data |
| rx_act | input | 1 | Receive activity strobe |
| tx_en | input | 1 | Transmit watchdog enable |
| tx_limit | input | 8 | Transmit timeout limit in ticks |
| tx_shift | input | 3 | Transmit prescaler shift |
| tx_waiting | input | 1 | Transmit channel is waiting for data |
| tx_act | input | 1 | Transmit activity strobe |
| irq_ena | input | 2 | Interrupt enable per source |
| irq_clr | input | 2 | Clear per source; a one clears the raw bit |
| irq_raw | output | 2 | Sticky raw hang bits |
| irq_status | output | 2 | Masked status bits |
| irq_o | output | 1 | Interrupt line |

## Verification
A prescaler that counts wrong or a timeout counter that is off by one changes the edge at which the raw bit rises by T+1 cycles or more. The bench therefore checks the bit on the edge just before the expected one and again on the expected edge.

A timeout counter that wraps, or that is not cleared by activity, shows up only after many ticks. It appears either as a missed re-raise right after a clear, or as a hang during traffic that is still active. A lost set-over-clear priority shows in the single cycle where a tick meets a clear.

// File: rtl/hang_watchdog.sv
module hang_watchdog #(
  parameter int BASE  = 8000,
  parameter int PRE_W = 17,
  parameter int LIM_W = 8,
  parameter int SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [LIM_W-1:0] rx_limit,
  input  logic [SH_W-1:0]  rx_shift,
  input  logic             rx_waiting,
  input  logic             rx_act,
  input  logic             tx_en,
  input  logic [LIM_W-1:0] tx_limit,
  input  logic [SH_W-1:0]  tx_shift,
  input  logic             tx_waiting,
  input  logic             tx_act,
  input  logic [1:0]       irq_ena,
  input  logic [1:0]       irq_clr,
  output logic [1:0]       irq_raw,
  output logic [1:0]       irq_status,
  output logic             irq_o
);
  localparam int NCH = 2;
  localparam logic [PRE_W-1:0] BASE_V = PRE_W'(BASE);
  localparam logic [LIM_W-1:0] TC_MAX = '1;

  logic [NCH-1:0]            en_a, wt_a, act_a, hit_a;
  logic [NCH-1:0][LIM_W-1:0] lim_a;
  logic [NCH-1:0][SH_W-1:0]  sh_a;
  logic [NCH-1:0][PRE_W-1:0] pc_a;
  logic [NCH-1:0][LIM_W-1:0] tc_a;

  assign en_a  = {tx_en, rx_en};
  assign wt_a  = {tx_waiting, rx_waiting};
  assign act_a = {tx_act, rx_act};
  assign lim_a = {tx_limit, rx_limit};
  assign sh_a  = {tx_shift, rx_shift};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PRE_W-1:0] pc;
    logic [LIM_W-1:0] tc;
    logic             raw;
    logic [PRE_W-1:0] thr;
    logic             tick;

    assign thr  = BASE_V >> sh_a[c];
    assign tick = en_a[c] && !act_a[c] && (pc >= thr);
    assign hit_a[c] = tick && wt_a[c] && (tc >= lim_a[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          pc <= '0;
      else if (!en_a[c] || act_a[c] || tick) pc <= '0;
      else                                 pc <= pc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                tc <= '0;
      else if (!en_a[c] || act_a[c] || !wt_a[c]) tc <= '0;
      else if (tick && tc != TC_MAX)             tc <= tc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          raw <= 1'b0;
      else if (hit_a[c])   raw <= 1'b1;
      else if (irq_clr[c]) raw <= 1'b0;
    end

    assign pc_a[c]    = pc;
    assign tc_a[c]    = tc;
    assign irq_raw[c] = raw;
  end

  assign irq_status = irq_raw & irq_ena;
  assign irq_o      = |irq_status;
endmodule

// File: rtl/hang_watchdog_chk.sv
module hang_watchdog_chk #(
  parameter int PRE_W = 17,
  parameter int LIM_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            en,
  input logic [1:0]            wt,
  input logic [1:0]            act,
  input logic [1:0]            clr,
  input logic [1:0]            hit,
  input logic [1:0]            raw,
  input logic [1:0]            status,
  input logic                  irq,
  input logic [1:0][PRE_W-1:0] pc,
  input logic [1:0][LIM_W-1:0] tc
);
  localparam logic [LIM_W-1:0] TCM = '1;

  for (genvar c = 0; c < 2; c++) begin : g_a
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      raw[c] && !clr[c] |=> raw[c]); // R7
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      clr[c] && !hit[c] |=> !raw[c]); // R7
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en[c] && !raw[c] |=> !raw[c]); // R4
    AST_DISABLED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !en[c] |=> pc[c] == '0 && tc[c] == '0); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !wt[c] && !raw[c] |=> !raw[c]); // R5
    AST_ACT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      act[c] |=> pc[c] == '0 && tc[c] == '0); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tc[c] == TCM |=> tc[c] == TCM || tc[c] == '0); // R10
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status != 2'b00)); // R8
  AST_STATUS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~raw) == 2'b00); // R8
endmodule

bind hang_watchdog hang_watchdog_chk #(.PRE_W(PRE_W), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_a), .wt(wt_a), .act(act_a), .clr(irq_clr),
  .hit(hit_a), .raw(irq_raw), .status(irq_status), .irq(irq_o), .pc(pc_a), .tc(tc_a)
);

// File: tb/hang_watchdog_test.sv
`timescale 1ns/1ps
module hang_watchdog_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] en = '0, wt = '0, act = '0, ena = 2'b11, clr = '0;
  logic [1:0][7:0] lim = '0;
  logic [1:0][2:0] sh = '0;
  logic [1:0] raw, status;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hang_watchdog uut (
    .clk(clk), .rst_n(rst_n),
    .rx_en(en[0]), .rx_limit(lim[0]), .rx_shift(sh[0]), .rx_waiting(wt[0]), .rx_act(act[0]),
    .tx_en(en[1]), .tx_limit(lim[1]), .tx_shift(sh[1]), .tx_waiting(wt[1]), .tx_act(act[1]),
    .irq_ena(ena), .irq_clr(clr), .irq_raw(raw), .irq_status(status), .irq_o(irq)
  );

  function automatic int tick_per(input int s);
    return (8000 >> s) + 1;
  endfunction

  function automatic int hang_edges(input int l, input int s);
    return (l + 1) * tick_per(s);
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_ch(input int c);
    wt[c] = 1'b0; clr[c] = 1'b1;
    step(1);
    clr[c] = 1'b0;
  endtask

  // restart channel c with activity while waiting; returns after edge E0
  task automatic sync_ch(input int c, input int l, input int s);
    lim[c] = 8'(l); sh[c] = 3'(s); en[c] = 1'b1; wt[c] = 1'b1; act[c] = 1'b1;
    step(1);
    act[c] = 1'b0;
  endtask

  task automatic hang_run(input int c, input int l, input int s, input string req);
    logic other;
    int n;
    clear_ch(c);
    other = raw[1-c];
    n = hang_edges(l, s);
    sync_ch(c, l, s);
    step(n - 1);
    check({req, " raw before deadline"}, raw[c], 0);
    step(1);
    check({req, " raw at deadline"}, raw[c], 1);
    check("R9 other channel untouched", raw[1-c], other);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #23;
    check("R7 reset raw", raw, 0);
    check("R8 reset irq", irq, 0);
    rst_n = 1'b1;
    step(2);

    // R1/R3: shift 0 gives 8001-cycle tick; limit 0 hangs on first tick
    hang_run(0, 0, 0, "R1 R3 shift0");
    hang_run(1, 0, 7, "R3 shift7");
    hang_run(1, 3, 6, "R2 tx");

    // R8 masking
    clear_ch(0); clear_ch(1);
    hang_run(0, 1, 7, "R2 rx");
    for (int m = 0; m < 4; m++) begin
      ena = 2'(m);
      #1;
      check("R8 status", status, int'(raw & ena));
      check("R8 irq", irq, int'((raw & ena) != 0));
    end
    ena = 2'b11;

    // R7 sticky
    wt[0] = 1'b0;
    step(200);
    check("R7 sticky", raw[0], 1);

    // R7 set wins over clear, then clear works
    clear_ch(0);
    sync_ch(0, 0, 7);
    step(63);
    check("R7 first hang", raw[0], 1);
    step(62);
    clr[0] = 1'b1;
    step(1);
    clr[0] = 1'b0;
    check("R7 set beats clear", raw[0], 1);
    clr[0] = 1'b1;
    step(1);
    clr[0] = 1'b0;
    check("R7 clear", raw[0], 0);

    // R4 disabled
    clear_ch(1);
    lim[1] = 0; sh[1] = 7; en[1] = 1'b0; wt[1] = 1'b1;
    step(500);
    check("R4 disabled no hang", raw[1], 0);

    // R5 not waiting
    en[1] = 1'b1; wt[1] = 1'b0;
    step(500);
    check("R5 idle no hang", raw[1], 0);
    wt[1] = 1'b1;
    step(64);
    check("R5 hang after waiting resumes", raw[1], 1);

    // R6 activity keeps restarting
    clear_ch(1);
    sync_ch(1, 2, 7);
    for (int k = 0; k < 5; k++) begin
      step(150);
      act[1] = 1'b1;
      step(1);
      act[1] = 1'b0;
    end
    check("R6 no hang under activity", raw[1], 0);
    step(hang_edges(2, 7) - 1);
    check("R6 restart timing early", raw[1], 0);
    step(1);
    check("R6 restart timing", raw[1], 1);

    // R10 saturation: limit 255, re-raise on next tick after clear
    hang_run(0, 255, 7, "R10 limit255");
    clr[0] = 1'b1;
    step(1);
    clr[0] = 1'b0;
    check("R10 cleared", raw[0], 0);
    step(61);
    check("R10 before next tick", raw[0], 0);
    step(1);
    check("R10 re-raised", raw[0], 1);

    // random mix
    for (int i = 0; i < 8; i++) begin
      int c, l, s;
      c = int'($urandom_range(1, 0));
      l = int'($urandom_range(7, 0));
      s = int'($urandom_range(7, 4));
      hang_run(c, l, s, "R2 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule